// File: doc/BRIEF.md
# Self-Correcting Decade Ring Counter

This block is a ten-state counter built on a five-stage twisted ring. The ring fills with ones from the bottom and then drains them. The ten legal ring patterns are decoded into ten one-hot state lines. An active-low carry covers the upper half of the count, so its rising edge marks the wrap from the last state back to state zero and can step a following counter.

Two count-control inputs are sampled by the system clock through synchronisers. One counts on its rising edge while the other is low. The other counts on its falling edge while the first is high. Each input therefore enables the other. At most one count is taken per system clock.

A clear input forces state zero and has priority over everything else. A synchronous load path can place any 5-bit pattern in the ring, which makes it possible to exercise recovery from illegal patterns. The next-state logic folds every illegal pattern back into the legal loop within a bounded number of counts.

Top module: `decade_ring_counter`

## Requirements
- R1: While rst_ni is low, dec_o is 10'b0000000001 (state 0 only) and carry_n_o is high.
- R2: A low-to-high change of rise_cnt_i while fall_cnt_i is low advances the counter by exactly one state.
- R3: A high-to-low change of fall_cnt_i while rise_cnt_i is high advances the counter by exactly one state.
- R4: No count occurs for a falling rise_cnt_i, a rising fall_cnt_i, a rising rise_cnt_i while fall_cnt_i is high, a falling fall_cnt_i while rise_cnt_i is low, or steady inputs.
- R5: A rising rise_cnt_i and a falling fall_cnt_i in the same clock give a single count, not two.
- R6: In a legal state exactly one bit of dec_o is high, bit k for state k. The count goes 0,1,...,9 and then back to 0.
- R7: carry_n_o is low in states 5 to 9 and high in states 0 to 4.
- R8: While clear_i is held high, the counter is in state 0 from the third clock edge on, whatever the count inputs do. Counting resumes from state 0 after release.
- R9: load_i high writes load_val_i into the ring at the next clock edge. A synchronised clear wins over load, and load wins over a count. Legal encoding: state k (k ≤ 5) has its k low ring bits set and the rest clear. State 5+j has its j low bits clear and the rest set.
- R10: From any of the 22 illegal ring patterns the counter is in the legal sequence after at most 11 counts.
- R11: A qualifying control edge changes the outputs at the third rising clk_i edge after the input change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rise_cnt_i | input | 1 | Counts on its rising edge while fall_cnt_i is low |
| fall_cnt_i | input | 1 | Counts on its falling edge while rise_cnt_i is high |
| clear_i | input | 1 | Forces state 0 while high (synchronised) |
| load_i | input | 1 | Synchronous ring load strobe |
| load_val_i | input | 5 | Ring pattern to load |
| dec_o | output | 10 | One-hot decoded state |
| carry_n_o | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
A corrupted ring shows at the ports at once, as a decode with no line high or with two lines high. The next count then moves it along a path that does not match the modulo-ten model. A wrong shift or a wrong correction term appears within one count as a skipped or repeated state line. A wrong recovery term shows up only after several counts, so every illegal pattern is loaded and followed through 11 counts and then a full lap. Edge-qualification faults change how many counts a given input change produces, and they are visible three clocks after the change.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int unsigned STAGES_DEF     = 5;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_LOAD,
    ACT_CLEAR
  } ring_act_e;
endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  if (DEPTH == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[DEPTH-2:0], d_i};
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/jdc_step.sv
module jdc_step (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_s_i,
  input  logic dn_s_i,
  output logic step_o
);
  logic up_q, dn_q;
  logic up_edge, dn_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_s_i;
      dn_q <= dn_s_i;
    end
  end

  // each input gates the other
  assign up_edge = up_s_i & ~up_q & ~dn_s_i;
  assign dn_edge = ~dn_s_i & dn_q & up_s_i;
  assign step_o  = up_edge | dn_edge;
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
#(
  parameter int unsigned STAGES = STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ring_act_e         act_i,
  input  logic [STAGES-1:0] load_val_i,
  output logic [STAGES-1:0] ring_o
);
  logic [STAGES-1:0] ring_q, nxt;

  always_comb begin
    nxt    = {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
    // drop an isolated one entering stage 2; legal codes pass unchanged
    nxt[2] = ring_q[1] & (ring_q[0] | ring_q[2]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= '0;
    else begin
      case (act_i)
        ACT_CLEAR: ring_q <= '0;
        ACT_LOAD:  ring_q <= load_val_i;
        ACT_STEP:  ring_q <= nxt;
        default:   ring_q <= ring_q;
      endcase
    end
  end

  assign ring_o = ring_q;
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned STATES = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring_i,
  output logic [STATES-1:0] dec_o
);
  for (genvar k = 0; k < STAGES; k++) begin : g_pair
    if (k == 0) begin : g_edge
      assign dec_o[0]      = ~ring_i[STAGES-1] & ~ring_i[0];
      assign dec_o[STAGES] =  ring_i[STAGES-1] &  ring_i[0];
    end else begin : g_mid
      assign dec_o[k]          = ring_i[k-1] & ~ring_i[k];
      assign dec_o[STAGES + k] = ring_i[k]   & ~ring_i[k-1];
    end
  end
endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter
  import jdc_pkg::*;
#(
  parameter int unsigned STAGES     = STAGES_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  localparam int unsigned STATES    = 2 * STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_cnt_i,
  input  logic              fall_cnt_i,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [STAGES-1:0] load_val_i,
  output logic [STATES-1:0] dec_o,
  output logic              carry_n_o
);
  logic [2:0]        sync_q;
  logic              up_s, dn_s, clr_s;
  logic              step;
  ring_act_e         act;
  logic [STAGES-1:0] ring_q;

  jdc_sync #(.WIDTH(3), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({clear_i, fall_cnt_i, rise_cnt_i}),
    .q_o    (sync_q)
  );

  assign {clr_s, dn_s, up_s} = sync_q;

  jdc_step u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .up_s_i (up_s),
    .dn_s_i (dn_s),
    .step_o (step)
  );

  always_comb begin
    if (clr_s)       act = ACT_CLEAR;
    else if (load_i) act = ACT_LOAD;
    else if (step)   act = ACT_STEP;
    else             act = ACT_HOLD;
  end

  jdc_ring #(.STAGES(STAGES)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .load_val_i (load_val_i),
    .ring_o     (ring_q)
  );

  jdc_decode #(.STAGES(STAGES)) u_dec (
    .ring_i (ring_q),
    .dec_o  (dec_o)
  );

  assign carry_n_o = ~ring_q[STAGES-1];
endmodule

// File: rtl/decade_ring_counter_chk.sv
module decade_ring_counter_chk #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned STATES = 2 * STAGES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STATES-1:0] dec_i,
  input logic              carry_n_i,
  input logic [STAGES-1:0] ring_i,
  input logic              step_i,
  input logic              clr_i,
  input logic              load_i,
  input logic [STAGES-1:0] load_val_i
);
  function automatic logic is_legal(logic [STAGES-1:0] s);
    return $countones(s[STAGES-1:1] ^ s[STAGES-2:0]) <= 1;
  endfunction

  logic [3:0] bad_steps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_steps <= '0;
    else if (clr_i || load_i || is_legal(ring_i)) bad_steps <= '0;
    else if (step_i && bad_steps != 4'hF) bad_steps <= bad_steps + 4'd1;
  end

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_legal(ring_i) |-> $countones(dec_i) == 1);

  assert_carry_span_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_legal(ring_i) |-> carry_n_i == ~|dec_i[STATES-1:STAGES]);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i && !load_i) |=> $stable(ring_i));

  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_legal(ring_i) && step_i && !clr_i && !load_i)
      |=> dec_i == {$past(dec_i[STATES-2:0]), $past(dec_i[STATES-1])});

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (dec_i == STATES'(1) && carry_n_i));

  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> ring_i == $past(load_val_i));

  assert_recover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_legal(ring_i) |-> bad_steps < 4'd11);
endmodule

bind decade_ring_counter decade_ring_counter_chk #(.STAGES(STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dec_i      (dec_o),
  .carry_n_i  (carry_n_o),
  .ring_i     (ring_q),
  .step_i     (step),
  .clr_i      (clr_s),
  .load_i     (load_i),
  .load_val_i (load_val_i)
);

// File: tb/tb_decade_ring_counter.sv
module tb_decade_ring_counter;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [9:0] dec;
    logic       carry;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rise_cnt = 1'b0, fall_cnt = 1'b0, clear = 1'b0, load = 1'b0;
  logic [4:0] load_val = '0;
  logic [9:0] dec;
  logic       carry_n;

  int   n_cmp = 0, n_bad = 0, cur = 0;
  exp_t sb_q[$];
  event sb_ev;

  decade_ring_counter dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rise_cnt_i (rise_cnt),
    .fall_cnt_i (fall_cnt),
    .clear_i    (clear),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_o      (dec),
    .carry_n_o  (carry_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial forever begin
    @(sb_ev);
    while (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check(dec == it.dec && carry_n == it.carry, it.tag,
            {21'd0, dec, carry_n}, {21'd0, it.dec, it.carry});
    end
  end

  task automatic expect_state(int idx, string tag);
    exp_t it;
    it.dec   = 10'b1 << idx;
    it.carry = (idx < 5);
    it.tag   = tag;
    sb_q.push_back(it);
    ->sb_ev;
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic up_pulse();
    rise_cnt = 1'b1; tick(3);
    rise_cnt = 1'b0; tick(3);
  endtask

  function automatic logic [4:0] legal_code(int k);
    if (k <= 5) return 5'((1 << k) - 1);
    return 5'(5'h1F & ~((1 << (k - 5)) - 1));
  endfunction

  function automatic bit is_legal_code(logic [4:0] c);
    for (int k = 0; k < 10; k++) if (legal_code(k) == c) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    expect_state(0, "R1 reset state");
    rst_ni = 1'b1;
    tick(2);
    cur = 0;

    // R11: latency of three clock edges
    rise_cnt = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    expect_state(cur, "R11 no change before third edge");
    @(posedge clk); @(negedge clk);
    cur = (cur + 1) % 10;
    expect_state(cur, "R11 change at third edge");
    rise_cnt = 1'b0; tick(3);
    expect_state(cur, "R4 falling rise_cnt no count");

    // R2/R6/R7: full lap and wrap
    for (int i = 0; i < 12; i++) begin
      up_pulse();
      cur = (cur + 1) % 10;
      expect_state(cur, "R2 R6 R7 rising rise_cnt count");
    end

    // R3 and R4 gating
    fall_cnt = 1'b1; tick(4);
    expect_state(cur, "R4 rising fall_cnt no count");
    rise_cnt = 1'b1; tick(4);
    expect_state(cur, "R4 rising rise_cnt while fall_cnt high");
    for (int i = 0; i < 5; i++) begin
      fall_cnt = 1'b0; tick(4);
      cur = (cur + 1) % 10;
      expect_state(cur, "R3 falling fall_cnt count");
      fall_cnt = 1'b1; tick(4);
      expect_state(cur, "R4 rising fall_cnt no count");
    end
    rise_cnt = 1'b0; tick(4);
    expect_state(cur, "R4 falling rise_cnt no count");
    fall_cnt = 1'b0; tick(4);
    expect_state(cur, "R4 falling fall_cnt while rise_cnt low");
    tick(6);
    expect_state(cur, "R4 steady inputs");

    // R5: simultaneous qualifying edges
    for (int i = 0; i < 3; i++) begin
      fall_cnt = 1'b1; tick(4);
      rise_cnt = 1'b1; fall_cnt = 1'b0; tick(4);
      cur = (cur + 1) % 10;
      expect_state(cur, "R5 simultaneous edges single count");
      rise_cnt = 1'b0; tick(4);
    end

    // R8: clear
    if (cur == 0) begin up_pulse(); cur = 1; end
    clear = 1'b1; tick(3);
    expect_state(0, "R8 clear forces state 0");
    for (int i = 0; i < 3; i++) up_pulse();
    fall_cnt = 1'b1; rise_cnt = 1'b1; tick(3);
    fall_cnt = 1'b0; tick(3);
    rise_cnt = 1'b0; tick(3);
    expect_state(0, "R8 counts blocked during clear");
    load_val = 5'b00111; load = 1'b1; tick(1);
    load = 1'b0;
    expect_state(0, "R9 clear wins over load");
    clear = 1'b0; tick(4);
    cur = 0;
    expect_state(0, "R8 state 0 after release");
    up_pulse(); cur = 1;
    expect_state(cur, "R8 counting resumes");

    // R9: load
    load_val = 5'b00111; load = 1'b1; tick(1); load = 1'b0;
    expect_state(3, "R9 load state 3");
    load_val = 5'b11100; load = 1'b1; tick(1); load = 1'b0;
    expect_state(7, "R9 load state 7");
    up_pulse();
    expect_state(8, "R9 count from loaded state");

    // R10: recovery from every illegal code
    for (int code = 0; code < 32; code++) begin
      if (!is_legal_code(5'(code))) begin
        int j;
        load_val = 5'(code); load = 1'b1; tick(1); load = 1'b0;
        for (int c = 0; c < 11; c++) up_pulse();
        check($countones(dec) == 1 && carry_n == ~|dec[9:5],
              $sformatf("R10 legal after 11 counts from %b", code[4:0]),
              {21'd0, dec, carry_n}, 32'd0);
        j = 0;
        for (int b = 0; b < 10; b++) if (dec[b]) j = b;
        if ($countones(dec) == 1) begin
          for (int c = 1; c <= 10; c++) begin
            up_pulse();
            expect_state((j + c) % 10, "R10 R6 lap after recovery");
          end
        end
      end
    end

    tick(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule